// File: doc/BRIEF.md
# Multi-Cycle Processor Sequencer

This block is the control unit of a 32-bit load/store processor that has no pipeline. One instruction runs at a time and takes five clock cycles. The unit runs a fixed round of phases: fetch, decode with register read, execute, memory and write-back. In each phase it raises the load enables of the datapath latches that the phase needs. It also drives the write strobes for data memory and for the register file. The datapath shows the unit only two fields of the latched instruction: the 6-bit major opcode and the 6-bit function field.

Decoding is purely combinational. From the two fields the unit derives a 4-bit ALU operation code, a signed flag for the ALU, and three multiplexer selects. The first select picks a register or the immediate as the second ALU operand. The second picks which instruction field gives the write-back register index. The third picks the ALU result or the memory data as the write-back value. The timing strobes come from a phase register, so they change only on a clock edge. The block has no data stream at its edge, so it has no valid/ready handshake. Every pin is a plain control level.

The datapath is expected to hold the instruction fields steady from the decode phase until the next fetch. The datapath owns the program counter. This unit only tells it when to advance to the next word, so a run fetches from 0, then 4, then 8, and so on.

Top module: `mp_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, the unit is in the fetch phase. `ir_load` and `pc_load` are 1. `rf_we`, `dmem_we` and `mdr_load` are 0.
- R2: Phases repeat in a strict five-cycle round with no overlap. Each phase raises its own set of enables:
  - fetch: `ir_load` and `pc_load`;
  - decode: `opa_load` and `opb_load`;
  - execute: `alu_out_load` and `cond_load`;
  - memory: the memory strobes only;
  - write-back: the register write only.
- R3: ALU code 0x0 is used by ADD (opcode 0x00, funct 0x20) and ADDI (opcode 0x08), both with signed 1. It is also used by ADDU (funct 0x21), ADDUI (opcode 0x09), LW (opcode 0x23) and SW (opcode 0x2B), all with signed 0.
- R4: ALU code 0x1 is used by SUB (funct 0x22) and SUBI (opcode 0x0A) with signed 1, and by SUBU (funct 0x23) with signed 0.
- R5: AND (funct 0x24) and ANDI (opcode 0x0C) give ALU code 0x2. OR (funct 0x25) gives 0x3. All three have signed 0.
- R6: SLT (funct 0x2A) and SLTU (funct 0x2B) give ALU code 0xB, with signed 1 and 0 respectively. MUL (funct 0x0E) and MULU (funct 0x16) give 0xE, with signed 1 and 0.
- R7: The function field is decoded only when the opcode is 0x00. For any other opcode it is ignored.
- R8: `alu_b_sel` is 1 (immediate) for ADDI, ADDUI, SUBI, ANDI, LW and SW. It is 0 (register) for register-form instructions.
- R9: `wb_idx_sel` is 1 (rd field) for register-form instructions. It is 0 (rt field) otherwise.
- R10: `rf_we` is 1 only in the write-back phase, and only for supported arithmetic, logic, compare, multiply and LW instructions. It is never 1 for SW.
- R11: `dmem_we` is 1 only in the memory phase of SW. `mdr_load` is 1 only in the memory phase of LW. `wb_data_sel` is 1 (memory data) only for LW.
- R12: An unsupported opcode, or an unsupported funct under opcode 0x00, still takes five cycles. It raises no `rf_we`, `dmem_we` or `mdr_load`, and gives ALU code 0x0 with signed 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 6 | Major opcode of the latched instruction |
| funct | input | 6 | Function field of the latched instruction |
| ir_load | output | 1 | Instruction latch load |
| pc_load | output | 1 | Program counter load (next word) |
| opa_load | output | 1 | First operand latch load |
| opb_load | output | 1 | Second operand latch load |
| alu_out_load | output | 1 | ALU result latch load |
| cond_load | output | 1 | Condition bit latch load |
| mdr_load | output | 1 | Memory data latch load |
| alu_b_sel | output | 1 | Second ALU operand: 1 immediate, 0 register |
| wb_idx_sel | output | 1 | Write index: 1 rd, 0 rt |
| wb_data_sel | output | 1 | Write value: 1 memory data, 0 ALU result |
| dmem_we | output | 1 | Data memory write strobe |
| rf_we | output | 1 | Register file write strobe |
| alu_op | output | 4 | ALU operation code |
| alu_signed | output | 1 | ALU signed flag |

## Verification
The bench builds the block with its default field widths: 6-bit opcode, 6-bit funct and 4-bit ALU code. These widths reach every encoding named above. They also reach the unused codes at the top of both fields, which drive the unsupported path. A program of twenty instructions runs back to back. It covers every supported encoding, both kinds of unsupported encoding, and I-type instructions that carry a nonzero funct. Every phase of every instruction is compared with a behavioural model.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

  // Instruction round: one phase per clock.
  typedef enum logic [2:0] {
    PH_FETCH  = 3'd0,
    PH_DECODE = 3'd1,
    PH_EXEC   = 3'd2,
    PH_MEM    = 3'd3,
    PH_WB     = 3'd4
  } phase_t;

  localparam int unsigned NUM_PHASES = 5;

  // Behaviour class of the decoded instruction.
  typedef enum logic [2:0] {
    IC_NONE  = 3'd0,
    IC_REG   = 3'd1,
    IC_IMM   = 3'd2,
    IC_LOAD  = 3'd3,
    IC_STORE = 3'd4
  } iclass_t;

  // Major opcodes.
  localparam logic [7:0] OPV_REG   = 8'h00;
  localparam logic [7:0] OPV_ADDI  = 8'h08;
  localparam logic [7:0] OPV_ADDUI = 8'h09;
  localparam logic [7:0] OPV_SUBI  = 8'h0A;
  localparam logic [7:0] OPV_ANDI  = 8'h0C;
  localparam logic [7:0] OPV_LOAD  = 8'h23;
  localparam logic [7:0] OPV_STORE = 8'h2B;

  // Function codes under the register opcode.
  localparam logic [7:0] FNV_MUL  = 8'h0E;
  localparam logic [7:0] FNV_MULU = 8'h16;
  localparam logic [7:0] FNV_ADD  = 8'h20;
  localparam logic [7:0] FNV_ADDU = 8'h21;
  localparam logic [7:0] FNV_SUB  = 8'h22;
  localparam logic [7:0] FNV_SUBU = 8'h23;
  localparam logic [7:0] FNV_AND  = 8'h24;
  localparam logic [7:0] FNV_OR   = 8'h25;
  localparam logic [7:0] FNV_SLT  = 8'h2A;
  localparam logic [7:0] FNV_SLTU = 8'h2B;

  // ALU operation codes.
  localparam logic [7:0] AV_ADD = 8'h0;
  localparam logic [7:0] AV_SUB = 8'h1;
  localparam logic [7:0] AV_AND = 8'h2;
  localparam logic [7:0] AV_OR  = 8'h3;
  localparam logic [7:0] AV_SLT = 8'hB;
  localparam logic [7:0] AV_MUL = 8'hE;

endpackage

// File: rtl/mpc_decode.sv
module mpc_decode
  import mpc_pkg::*;
#(
  parameter int unsigned OPC_W = 6,
  parameter int unsigned FN_W  = 6,
  parameter int unsigned ALU_W = 4
) (
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  output iclass_t          iclass,
  output logic [ALU_W-1:0] alu_op,
  output logic             alu_signed
);

  // Register-form sub-decode, only consulted under the register opcode.
  iclass_t          r_cls;
  logic [ALU_W-1:0] r_op;
  logic             r_sg;

  always_comb begin
    r_cls = IC_REG;
    r_op  = ALU_W'(AV_ADD);
    r_sg  = 1'b0;
    if      (funct == FN_W'(FNV_ADD))  begin r_op = ALU_W'(AV_ADD); r_sg = 1'b1; end
    else if (funct == FN_W'(FNV_ADDU)) begin r_op = ALU_W'(AV_ADD); r_sg = 1'b0; end
    else if (funct == FN_W'(FNV_SUB))  begin r_op = ALU_W'(AV_SUB); r_sg = 1'b1; end
    else if (funct == FN_W'(FNV_SUBU)) begin r_op = ALU_W'(AV_SUB); r_sg = 1'b0; end
    else if (funct == FN_W'(FNV_AND))  begin r_op = ALU_W'(AV_AND); r_sg = 1'b0; end
    else if (funct == FN_W'(FNV_OR))   begin r_op = ALU_W'(AV_OR);  r_sg = 1'b0; end
    else if (funct == FN_W'(FNV_SLT))  begin r_op = ALU_W'(AV_SLT); r_sg = 1'b1; end
    else if (funct == FN_W'(FNV_SLTU)) begin r_op = ALU_W'(AV_SLT); r_sg = 1'b0; end
    else if (funct == FN_W'(FNV_MUL))  begin r_op = ALU_W'(AV_MUL); r_sg = 1'b1; end
    else if (funct == FN_W'(FNV_MULU)) begin r_op = ALU_W'(AV_MUL); r_sg = 1'b0; end
    else                               begin r_cls = IC_NONE; end
  end

  // Major opcode decode.
  always_comb begin
    iclass     = IC_NONE;
    alu_op     = ALU_W'(AV_ADD);
    alu_signed = 1'b0;
    if (opcode == OPC_W'(OPV_REG)) begin
      iclass     = r_cls;
      alu_op     = r_op;
      alu_signed = r_sg;
    end else if (opcode == OPC_W'(OPV_ADDI)) begin
      iclass = IC_IMM;  alu_op = ALU_W'(AV_ADD); alu_signed = 1'b1;
    end else if (opcode == OPC_W'(OPV_ADDUI)) begin
      iclass = IC_IMM;  alu_op = ALU_W'(AV_ADD); alu_signed = 1'b0;
    end else if (opcode == OPC_W'(OPV_SUBI)) begin
      iclass = IC_IMM;  alu_op = ALU_W'(AV_SUB); alu_signed = 1'b1;
    end else if (opcode == OPC_W'(OPV_ANDI)) begin
      iclass = IC_IMM;  alu_op = ALU_W'(AV_AND); alu_signed = 1'b0;
    end else if (opcode == OPC_W'(OPV_LOAD)) begin
      iclass = IC_LOAD; alu_op = ALU_W'(AV_ADD); alu_signed = 1'b0;
    end else if (opcode == OPC_W'(OPV_STORE)) begin
      iclass = IC_STORE; alu_op = ALU_W'(AV_ADD); alu_signed = 1'b0;
    end
  end

endmodule

// File: rtl/mpc_phase.sv
module mpc_phase
  import mpc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_t phase
);

  phase_t phase_q;
  phase_t phase_d;

  always_comb begin
    unique case (phase_q)
      PH_FETCH:  phase_d = PH_DECODE;
      PH_DECODE: phase_d = PH_EXEC;
      PH_EXEC:   phase_d = PH_MEM;
      PH_MEM:    phase_d = PH_WB;
      default:   phase_d = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_FETCH;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;

endmodule

// File: rtl/mpc_strobe.sv
module mpc_strobe
  import mpc_pkg::*;
(
  input  phase_t  phase,
  input  iclass_t iclass,
  output logic    ir_load,
  output logic    pc_load,
  output logic    opa_load,
  output logic    opb_load,
  output logic    alu_out_load,
  output logic    cond_load,
  output logic    mdr_load,
  output logic    alu_b_sel,
  output logic    wb_idx_sel,
  output logic    wb_data_sel,
  output logic    dmem_we,
  output logic    rf_we
);

  logic writes_reg;
  logic uses_imm;

  always_comb begin
    writes_reg = (iclass == IC_REG) || (iclass == IC_IMM) || (iclass == IC_LOAD);
    uses_imm   = (iclass == IC_IMM) || (iclass == IC_LOAD) || (iclass == IC_STORE);
  end

  always_comb begin
    ir_load      = 1'b0;
    pc_load      = 1'b0;
    opa_load     = 1'b0;
    opb_load     = 1'b0;
    alu_out_load = 1'b0;
    cond_load    = 1'b0;
    mdr_load     = 1'b0;
    dmem_we      = 1'b0;
    rf_we        = 1'b0;
    unique case (phase)
      PH_FETCH: begin
        ir_load = 1'b1;
        pc_load = 1'b1;
      end
      PH_DECODE: begin
        opa_load = 1'b1;
        opb_load = 1'b1;
      end
      PH_EXEC: begin
        alu_out_load = 1'b1;
        cond_load    = 1'b1;
      end
      PH_MEM: begin
        mdr_load = (iclass == IC_LOAD);
        dmem_we  = (iclass == IC_STORE);
      end
      default: begin
        rf_we = writes_reg;
      end
    endcase
  end

  // Selects follow the decoded class; the phase strobes decide when they matter.
  always_comb begin
    alu_b_sel   = uses_imm;
    wb_idx_sel  = (iclass == IC_REG);
    wb_data_sel = (iclass == IC_LOAD);
  end

endmodule

// File: rtl/mp_ctrl.sv
module mp_ctrl
  import mpc_pkg::*;
#(
  parameter int unsigned OPC_W = 6,
  parameter int unsigned FN_W  = 6,
  parameter int unsigned ALU_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  output logic             ir_load,
  output logic             pc_load,
  output logic             opa_load,
  output logic             opb_load,
  output logic             alu_out_load,
  output logic             cond_load,
  output logic             mdr_load,
  output logic             alu_b_sel,
  output logic             wb_idx_sel,
  output logic             wb_data_sel,
  output logic             dmem_we,
  output logic             rf_we,
  output logic [ALU_W-1:0] alu_op,
  output logic             alu_signed
);

  phase_t  phase;
  iclass_t iclass;

  mpc_phase u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .phase (phase)
  );

  mpc_decode #(
    .OPC_W (OPC_W),
    .FN_W  (FN_W),
    .ALU_W (ALU_W)
  ) u_decode (
    .opcode     (opcode),
    .funct      (funct),
    .iclass     (iclass),
    .alu_op     (alu_op),
    .alu_signed (alu_signed)
  );

  mpc_strobe u_strobe (
    .phase        (phase),
    .iclass       (iclass),
    .ir_load      (ir_load),
    .pc_load      (pc_load),
    .opa_load     (opa_load),
    .opb_load     (opb_load),
    .alu_out_load (alu_out_load),
    .cond_load    (cond_load),
    .mdr_load     (mdr_load),
    .alu_b_sel    (alu_b_sel),
    .wb_idx_sel   (wb_idx_sel),
    .wb_data_sel  (wb_data_sel),
    .dmem_we      (dmem_we),
    .rf_we        (rf_we)
  );

endmodule

// File: rtl/mp_ctrl_chk.sv
module mp_ctrl_chk #(
  parameter int unsigned OPC_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [OPC_W-1:0] opcode,
  input logic             ir_load,
  input logic             pc_load,
  input logic             opa_load,
  input logic             alu_out_load,
  input logic             mdr_load,
  input logic             dmem_we,
  input logic             rf_we,
  input logic             wb_data_sel
);

  // Independent cycle counter of the instruction round.
  logic [2:0] rnd;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rnd <= 3'd0;
    else if (rnd == 3'd4) rnd <= 3'd0;
    else                 rnd <= rnd + 3'd1;
  end

  localparam logic [OPC_W-1:0] SW_OP = OPC_W'(8'h2B);

  p_fetch_every_fifth_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ir_load == (rnd == 3'd0));

  p_fetch_advances_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ir_load |-> pc_load);

  p_phase_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ir_load, opa_load, alu_out_load, mdr_load | dmem_we, rf_we}));

  p_rf_only_in_wb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (rnd == 3'd4));

  p_store_no_rf_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == SW_OP) |-> !rf_we);

  p_dmem_in_mem_of_store_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> ((rnd == 3'd3) && (opcode == SW_OP)));

  p_load_then_writeback_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mdr_load |=> (rf_we && wb_data_sel));

endmodule

bind mp_ctrl mp_ctrl_chk #(.OPC_W(OPC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .opcode       (opcode),
  .ir_load      (ir_load),
  .pc_load      (pc_load),
  .opa_load     (opa_load),
  .alu_out_load (alu_out_load),
  .mdr_load     (mdr_load),
  .dmem_we      (dmem_we),
  .rf_we        (rf_we),
  .wb_data_sel  (wb_data_sel)
);

// File: tb/mp_ctrl_bench.sv
module mp_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NPROG = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] opcode = 6'h00;
  logic [5:0] funct = 6'h00;
  logic ir_load, pc_load, opa_load, opb_load, alu_out_load, cond_load, mdr_load;
  logic alu_b_sel, wb_idx_sel, wb_data_sel, dmem_we, rf_we, alu_signed;
  logic [3:0] alu_op;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mp_ctrl u_mp_ctrl (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .funct(funct),
    .ir_load(ir_load), .pc_load(pc_load), .opa_load(opa_load), .opb_load(opb_load),
    .alu_out_load(alu_out_load), .cond_load(cond_load), .mdr_load(mdr_load),
    .alu_b_sel(alu_b_sel), .wb_idx_sel(wb_idx_sel), .wb_data_sel(wb_data_sel),
    .dmem_we(dmem_we), .rf_we(rf_we), .alu_op(alu_op), .alu_signed(alu_signed)
  );

  // Program: {opcode, funct}
  logic [11:0] prog [NPROG] = '{
    {6'h00, 6'h20}, {6'h00, 6'h21}, {6'h00, 6'h22}, {6'h00, 6'h23},
    {6'h00, 6'h24}, {6'h00, 6'h25}, {6'h00, 6'h2A}, {6'h00, 6'h2B},
    {6'h00, 6'h0E}, {6'h00, 6'h16}, {6'h08, 6'h00}, {6'h09, 6'h00},
    {6'h0A, 6'h00}, {6'h0C, 6'h00}, {6'h23, 6'h00}, {6'h2B, 6'h00},
    {6'h00, 6'h3F}, {6'h3F, 6'h20}, {6'h23, 6'h22}, {6'h2B, 6'h20}
  };

  // Reference decode. cls: 0 none, 1 register, 2 immediate, 3 load, 4 store
  task automatic ref_decode(input logic [5:0] op, input logic [5:0] fn,
                            output int cls, output logic [3:0] aop,
                            output logic sg, output string tag);
    cls = 0; aop = 4'h0; sg = 1'b0; tag = "R12";
    if (op == 6'h00) begin
      cls = 1;
      case (fn)
        6'h20: begin aop = 4'h0; sg = 1; tag = "R3"; end
        6'h21: begin aop = 4'h0; sg = 0; tag = "R3"; end
        6'h22: begin aop = 4'h1; sg = 1; tag = "R4"; end
        6'h23: begin aop = 4'h1; sg = 0; tag = "R4"; end
        6'h24: begin aop = 4'h2; sg = 0; tag = "R5"; end
        6'h25: begin aop = 4'h3; sg = 0; tag = "R5"; end
        6'h2A: begin aop = 4'hB; sg = 1; tag = "R6"; end
        6'h2B: begin aop = 4'hB; sg = 0; tag = "R6"; end
        6'h0E: begin aop = 4'hE; sg = 1; tag = "R6"; end
        6'h16: begin aop = 4'hE; sg = 0; tag = "R6"; end
        default: begin cls = 0; tag = "R12"; end
      endcase
    end else begin
      case (op)
        6'h08: begin cls = 2; aop = 4'h0; sg = 1; tag = "R3/R7"; end
        6'h09: begin cls = 2; aop = 4'h0; sg = 0; tag = "R3/R7"; end
        6'h0A: begin cls = 2; aop = 4'h1; sg = 1; tag = "R4/R7"; end
        6'h0C: begin cls = 2; aop = 4'h2; sg = 0; tag = "R5/R7"; end
        6'h23: begin cls = 3; aop = 4'h0; sg = 0; tag = "R3/R7"; end
        6'h2B: begin cls = 4; aop = 4'h0; sg = 0; tag = "R3/R7"; end
        default: begin cls = 0; tag = "R12"; end
      endcase
    end
  endtask

  task automatic chk(input string name, input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, name, act, exp, $time);
    end
  endtask

  // Compare every output with the model for round phase p.
  task automatic check_all(input int p, input bit in_reset);
    int cls;
    logic [3:0] aop;
    logic sg;
    string tag, ptag, wtag;
    ref_decode(opcode, funct, cls, aop, sg, tag);
    ptag = in_reset ? "R1" : "R2";
    wtag = (cls == 0) ? "R12" : "R10";
    chk("ir_load",      ir_load,      p == 0, ptag);
    chk("pc_load",      pc_load,      p == 0, ptag);
    chk("opa_load",     opa_load,     p == 1, "R2");
    chk("opb_load",     opb_load,     p == 1, "R2");
    chk("alu_out_load", alu_out_load, p == 2, "R2");
    chk("cond_load",    cond_load,    p == 2, "R2");
    chk("mdr_load",     mdr_load,     (p == 3) && (cls == 3), (cls == 0) ? "R12" : "R11");
    chk("dmem_we",      dmem_we,      (p == 3) && (cls == 4), (cls == 0) ? "R12" : "R11");
    chk("rf_we",        rf_we,        (p == 4) && (cls >= 1) && (cls <= 3), wtag);
    chk("wb_data_sel",  wb_data_sel,  cls == 3, "R11");
    chk("alu_b_sel",    alu_b_sel,    cls >= 2, "R8");
    chk("wb_idx_sel",   wb_idx_sel,   cls == 1, "R9");
    chk("alu_op",       alu_op,       aop, tag);
    chk("alu_signed",   alu_signed,   sg, tag);
  endtask

  initial begin
    // R1: reset holds fetch, unknown register funct 0x00 keeps writes quiet
    repeat (3) begin
      @(negedge clk);
      check_all(0, 1'b1);
    end
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    for (int i = 0; i < NPROG; i++) begin
      for (int p = 0; p < 5; p++) begin
        check_all(p, (i == 0) && (p == 0));
        if (p == 0) {opcode, funct} = prog[i];
        @(negedge clk);
      end
    end
    // Final fetch after the last instruction: round wraps (R2)
    check_all(0, 1'b0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule